// File: doc/BRIEF.md
# DMA Request Capture and Unit Sequencer

This block sits between three external DMA request pins and the bus. Each request pin is synchronized, qualified by pulse width and, once accepted, remembered in a per-channel pending flag. The requester may therefore drop its request before the acknowledge appears. A single sequencer then serves one channel at a time. It runs a transfer unit made of read accesses and write accesses, and drives active-low read and write strobes, a per-channel acknowledge and a per-channel end-of-process pulse.

Four request modes set how much work one request buys: a single access (step), one unit (block), every remaining unit (burst), or repeated units for as long as the request is held (continuous). In continuous mode the request is sampled once per unit, a fixed margin before the read strobe rises on the unit's last read. The margin is 3 cycles for an external source and 4 cycles for an external destination. Address generation, bus arbitration and register programming are outside the block: the block size, wait count, transfer count and mode arrive as plain inputs.

Top module: `dma_req_seq`

## Requirements
- R1: While reset is asserted and after reset is released, all acknowledges and end-of-process outputs are low, both strobes are high and no pending flag is set.
- R2: A request is accepted only after it has been high at two consecutive rising clock edges. A single-cycle pulse leaves the pending flag clear and starts no access.
- R3: An accepted request is held in the pending flag until its unit starts. A request released right after acceptance still produces its transfer, and a unit starts only for a pending channel.
- R4: When several channels are pending, the lowest-numbered channel is served first. At most one acknowledge is high at any time.
- R5: Each access drives rd_n_o low for W cycles and then wr_n_o low for W cycles, where W is wait_i, or 1 when wait_i is 0. The two strobes are never low together, and the served channel's acknowledge stays high whenever a strobe is low.
- R6: mode_i encoding is 0 block, 1 step, 2 burst, 3 continuous. In block mode one request performs one unit of blk_size_i accesses, and a blk_size_i of 0 counts as 1.
- R7: In step mode one request performs exactly one access.
- R8: In burst mode one request performs every remaining unit of the channel back to back.
- R9: In continuous mode the unit repeats while the request is held. The request is sampled at the cycle that lies M cycles before the read strobe rises on the unit's last read, with M = 4 when dst_ext_i is 1 and M = 3 otherwise. A request removed well before that point stops the channel after the current unit. A request removed after that point causes exactly one more unit.
- R10: Removing the request during a unit never shortens that unit.
- R11: deop_o of the channel is a single-cycle pulse during the last write cycle of the unit that brings the channel's unit count to zero. The channel is then disabled, and later requests on it are ignored.
- R12: A pulse on ch_arm_i loads xfer_cnt_i as the channel's unit count, enables the channel and clears its pending flag. Requests on a channel that has never been armed are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_i | input | NCH | Asynchronous request pins, one per channel |
| ch_arm_i | input | NCH | Arm pulse per channel |
| xfer_cnt_i | input | CNT_W | Unit count loaded on arm |
| mode_i | input | 2 | Request mode (0 block, 1 step, 2 burst, 3 continuous) |
| blk_size_i | input | BLK_W | Accesses per unit |
| wait_i | input | WAIT_W | Cycles per strobe, 0 treated as 1 |
| dst_ext_i | input | 1 | Selects the 4-cycle continuous stop margin |
| dack_o | output | NCH | Acknowledge of the channel being served |
| deop_o | output | NCH | End-of-process pulse |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| pend_o | output | NCH | Accepted-request flags |

## Verification
The assertions assume that mode_i, blk_size_i, wait_i and dst_ext_i stay constant while a channel is being served, and that ch_arm_i is pulsed only while the sequencer is idle. The stimulus changes configuration and arms channels only after the previous transfer has fully drained. Request pins are driven on the falling edge, so every pulse covers a whole number of sampling edges. The continuous-mode requests are removed either well before or well after the sample point, never on the boundary cycle itself.

// File: rtl/dma_rs_pkg.sv
package dma_rs_pkg;
  typedef enum logic [1:0] {
    MODE_BLOCK = 2'd0,
    MODE_STEP  = 2'd1,
    MODE_BURST = 2'd2,
    MODE_CONT  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } sq_state_e;
endpackage

// File: rtl/dma_rs_chan.sv
// Per-channel request front end: synchronizer, width qualifier,
// pending flag, enable and remaining unit count.
module dma_rs_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dreq_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] cnt_load_i,
  input  logic             start_i,
  input  logic             unit_end_i,
  output logic             req_lvl_o,
  output logic             pend_o,
  output logic             last_o
);
  logic             sync1_q, sync2_q;
  logic [1:0]       wc_q, wc_d;
  logic             pend_q, pend_d;
  logic             en_q, en_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire, finish, ctl_en;

  // second consecutive high sample qualifies the request
  assign fire   = sync2_q && (wc_q == 2'd1) && en_q;
  assign finish = unit_end_i && (cnt_q == CNT_W'(1));
  assign ctl_en = arm_i | fire | start_i | unit_end_i;

  always_comb begin
    wc_d = wc_q;
    if (!sync2_q)           wc_d = 2'd0;
    else if (wc_q != 2'd2)  wc_d = wc_q + 2'd1;

    pend_d = pend_q;
    en_d   = en_q;
    cnt_d  = cnt_q;
    if (arm_i) begin
      pend_d = 1'b0;
      en_d   = (cnt_load_i != '0);
      cnt_d  = cnt_load_i;
    end else begin
      if (fire)         pend_d = 1'b1;
      else if (start_i) pend_d = 1'b0;
      if (unit_end_i && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
      if (finish) begin
        en_d   = 1'b0;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      wc_q    <= 2'd0;
    end else begin
      sync1_q <= dreq_i;
      sync2_q <= sync1_q;
      wc_q    <= wc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (ctl_en) begin
      pend_q <= pend_d;
      en_q   <= en_d;
      cnt_q  <= cnt_d;
    end
  end

  assign req_lvl_o = sync2_q;
  assign pend_o    = pend_q;
  assign last_o    = en_q && (cnt_q == CNT_W'(1));

  assert_start_needs_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> pend_q);
  assert_disable_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end_i && last_o && !arm_i) |=> (!en_q && !pend_q));
  assert_no_pend_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !arm_i && $past(!en_q)) |-> !pend_q);
endmodule

// File: rtl/dma_rs_arb.sv
// Fixed-priority grant, channel 0 highest.
module dma_rs_arb #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] gnt_o
);
  logic [NCH:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_prio
    assign seen[i+1] = seen[i] | req_i[i];
    assign gnt_o[i]  = req_i[i] & ~seen[i];
  end
endmodule

// File: rtl/dma_rs_seq.sv
// Unit sequencer: read/write strobes, acknowledge, end-of-process,
// continuation decision.
module dma_rs_seq
  import dma_rs_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int BLK_W  = 4,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pend_i,
  input  logic [NCH-1:0]    last_i,
  input  logic [NCH-1:0]    req_lvl_i,
  input  xfer_mode_e        mode_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              dst_ext_i,
  output logic [NCH-1:0]    start_o,
  output logic [NCH-1:0]    unit_end_o,
  output logic [NCH-1:0]    dack_o,
  output logic [NCH-1:0]    deop_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  localparam int UCNT_W = BLK_W + WAIT_W + 2;
  localparam logic [UCNT_W-1:0] MARG_SRC = UCNT_W'(3);
  localparam logic [UCNT_W-1:0] MARG_DST = UCNT_W'(4);

  sq_state_e         state_q, state_d;
  logic [NCH-1:0]    ch_q, ch_d, gnt;
  logic [BLK_W-1:0]  acc_q, acc_d, usize;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d, w_eff, w_first;
  logic [UCNT_W-1:0] ucnt_q, ucnt_d, last_rd, marg, samp, us_x, w_x;
  logic              keep_q, keep_d;
  logic              req_cur, last_cur, unit_done, again, seq_en;

  dma_rs_arb #(.NCH(NCH)) i_arb (.req_i(pend_i), .gnt_o(gnt));

  assign w_eff   = (wait_i == '0) ? WAIT_W'(1) : wait_i;
  assign w_first = w_eff - WAIT_W'(1);
  assign usize   = (mode_i == MODE_STEP || blk_i == '0) ? BLK_W'(1) : blk_i;
  assign us_x    = UCNT_W'(usize);
  assign w_x     = UCNT_W'(w_eff);
  // index of the final read cycle inside the unit
  assign last_rd = (us_x - UCNT_W'(1)) * (w_x << 1) + w_x - UCNT_W'(1);
  assign marg    = dst_ext_i ? MARG_DST : MARG_SRC;
  assign samp    = (last_rd + UCNT_W'(1) > marg) ? (last_rd + UCNT_W'(1) - marg) : '0;

  assign req_cur   = |(req_lvl_i & ch_q);
  assign last_cur  = |(last_i & ch_q);
  assign unit_done = (state_q == SQ_WRITE) && (wcnt_q == '0) && (acc_q == BLK_W'(1));
  assign again     = !last_cur && ((mode_i == MODE_BURST) || (mode_i == MODE_CONT && keep_q));
  assign seq_en    = (state_q != SQ_IDLE) || (|gnt);

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    acc_d   = acc_q;
    wcnt_d  = wcnt_q;
    ucnt_d  = ucnt_q;
    keep_d  = keep_q;
    case (state_q)
      SQ_IDLE: begin
        if (|gnt) begin
          state_d = SQ_READ;
          ch_d    = gnt;
          acc_d   = usize;
          wcnt_d  = w_first;
          ucnt_d  = '0;
          keep_d  = 1'b0;
        end
      end
      SQ_READ: begin
        ucnt_d = ucnt_q + UCNT_W'(1);
        if (wcnt_q == '0) begin
          state_d = SQ_WRITE;
          wcnt_d  = w_first;
        end else begin
          wcnt_d = wcnt_q - WAIT_W'(1);
        end
      end
      SQ_WRITE: begin
        ucnt_d = ucnt_q + UCNT_W'(1);
        if (wcnt_q != '0) begin
          wcnt_d = wcnt_q - WAIT_W'(1);
        end else if (acc_q != BLK_W'(1)) begin
          state_d = SQ_READ;
          acc_d   = acc_q - BLK_W'(1);
          wcnt_d  = w_first;
        end else if (again) begin
          state_d = SQ_READ;
          acc_d   = usize;
          wcnt_d  = w_first;
          ucnt_d  = '0;
        end else begin
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
    if (state_q != SQ_IDLE && ucnt_q == samp) keep_d = req_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ch_q    <= '0;
      acc_q   <= '0;
      wcnt_q  <= '0;
      ucnt_q  <= '0;
      keep_q  <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_d;
      ch_q    <= ch_d;
      acc_q   <= acc_d;
      wcnt_q  <= wcnt_d;
      ucnt_q  <= ucnt_d;
      keep_q  <= keep_d;
    end
  end

  assign start_o    = (state_q == SQ_IDLE) ? gnt : '0;
  assign unit_end_o = unit_done ? ch_q : '0;
  assign deop_o     = (unit_done && last_cur) ? ch_q : '0;
  assign dack_o     = (state_q != SQ_IDLE) ? ch_q : '0;
  assign rd_n_o     = (state_q != SQ_READ);
  assign wr_n_o     = (state_q != SQ_WRITE);

  assert_dack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_o));
  assert_strobe_has_dack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o) |-> (|dack_o));
  assert_write_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n_o) |-> $past(!rd_n_o));
  assert_deop_in_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|deop_o) |-> (!wr_n_o && (deop_o == dack_o)));
  assert_deop_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|deop_o) |=> (deop_o == '0));
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_rs_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CNT_W  = 8,
  parameter int BLK_W  = 4,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    dreq_i,
  input  logic [NCH-1:0]    ch_arm_i,
  input  logic [CNT_W-1:0]  xfer_cnt_i,
  input  logic [1:0]        mode_i,
  input  logic [BLK_W-1:0]  blk_size_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              dst_ext_i,
  output logic [NCH-1:0]    dack_o,
  output logic [NCH-1:0]    deop_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [NCH-1:0]    pend_o
);
  logic           rs1_q, rs2_q;
  logic [NCH-1:0] req_lvl, pend, last, start, unit_end;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_rs_chan #(.CNT_W(CNT_W)) i_chan (
      .clk        (clk),
      .rst_n      (rs2_q),
      .dreq_i     (dreq_i[c]),
      .arm_i      (ch_arm_i[c]),
      .cnt_load_i (xfer_cnt_i),
      .start_i    (start[c]),
      .unit_end_i (unit_end[c]),
      .req_lvl_o  (req_lvl[c]),
      .pend_o     (pend[c]),
      .last_o     (last[c])
    );
  end

  dma_rs_seq #(.NCH(NCH), .BLK_W(BLK_W), .WAIT_W(WAIT_W)) i_seq (
    .clk        (clk),
    .rst_n      (rs2_q),
    .pend_i     (pend),
    .last_i     (last),
    .req_lvl_i  (req_lvl),
    .mode_i     (xfer_mode_e'(mode_i)),
    .blk_i      (blk_size_i),
    .wait_i     (wait_i),
    .dst_ext_i  (dst_ext_i),
    .start_o    (start),
    .unit_end_o (unit_end),
    .dack_o     (dack_o),
    .deop_o     (deop_o),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o)
  );

  assign pend_o = pend;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rs2_q |-> (rd_n_o && wr_n_o && dack_o == '0 && deop_o == '0));
endmodule

// File: tb/test_dma_req_seq.sv
module test_dma_req_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] dreq = '0, arm = '0;
  logic [7:0] xcnt = '0;
  logic [1:0] mode = '0;
  logic [3:0] blk = 4'd1;
  logic [2:0] wt = 3'd1;
  logic       dext = 1'b0;
  logic [2:0] dack, deop, pend;
  logic       rd_n, wr_n;

  dma_req_seq i_dma_req_seq (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .ch_arm_i(arm), .xfer_cnt_i(xcnt),
    .mode_i(mode), .blk_size_i(blk), .wait_i(wt), .dst_ext_i(dext),
    .dack_o(dack), .deop_o(deop), .rd_n_o(rd_n), .wr_n_o(wr_n), .pend_o(pend));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // running monitors (never reset; tests take differences)
  int acc_cnt = 0, rd_cyc = 0, eop_cyc = 0, bad = 0, n_log = 0;
  logic [2:0] log_q [0:15];
  logic prev_wr = 1'b1;
  logic [2:0] prev_dack = '0;
  always @(negedge clk) begin
    if (!wr_n && prev_wr) acc_cnt++;
    if (!rd_n) rd_cyc++;
    if (deop != 3'b0) eop_cyc++;
    if ((!rd_n || !wr_n) && dack == 3'b0) bad++;
    if (!rd_n && !wr_n) bad++;
    if (deop != 3'b0 && wr_n) bad++;
    if (dack != 3'b0 && prev_dack == 3'b0 && n_log < 16) begin
      log_q[n_log] = dack;
      n_log++;
    end
    prev_wr = wr_n;
    prev_dack = dack;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic arm_ch(input logic [2:0] m, input logic [7:0] n);
    @(negedge clk); xcnt = n; arm = m;
    @(negedge clk); arm = '0;
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    @(negedge clk); dreq = m;
    repeat (n) @(negedge clk);
    dreq = '0;
  endtask

  typedef struct packed {
    logic [1:0] mode; logic [3:0] blk; logic [2:0] wt; logic [7:0] cnt;
    logic [2:0] ch; logic [3:0] plen; logic [7:0] e_acc; logic [7:0] e_rd; logic [1:0] e_eop;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 4'd4, 3'd1, 8'd3, 3'b001, 4'd1, 8'd0, 8'd0, 2'd0},
    '{2'd0, 4'd4, 3'd1, 8'd3, 3'b001, 4'd2, 8'd4, 8'd4, 2'd0},
    '{2'd0, 4'd3, 3'd2, 8'd3, 3'b010, 4'd5, 8'd3, 8'd6, 2'd0},
    '{2'd1, 4'd4, 3'd1, 8'd3, 3'b100, 4'd3, 8'd1, 8'd1, 2'd0},
    '{2'd2, 4'd2, 3'd1, 8'd3, 3'b001, 4'd2, 8'd6, 8'd6, 2'd1},
    '{2'd2, 4'd2, 3'd0, 8'd2, 3'b010, 4'd2, 8'd4, 8'd4, 2'd1},
    '{2'd0, 4'd1, 3'd3, 8'd1, 3'b100, 4'd2, 8'd1, 8'd3, 2'd1}
  };
  localparam string VTAG [7] = '{"R2", "R3", "R6", "R7", "R8", "R5", "R11"};

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0, r0, e0, l0;
    repeat (3) @(negedge clk);
    // R1: reset state, during and after reset
    chk("R1 rd_n in reset", int'(rd_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd_n", int'(rd_n), 1);
    chk("R1 wr_n", int'(wr_n), 1);
    chk("R1 dack", int'(dack), 0);
    chk("R1 deop", int'(deop), 0);
    chk("R1 pend", int'(pend), 0);

    // R12: unarmed channel ignores requests
    a0 = acc_cnt;
    pulse(3'b010, 4);
    repeat (20) @(negedge clk);
    chk("R12 unarmed pend", int'(pend), 0);
    chk("R12 unarmed accesses", acc_cnt - a0, 0);

    // vector table
    for (int v = 0; v < 7; v++) begin
      mode = VECS[v].mode; blk = VECS[v].blk; wt = VECS[v].wt;
      arm_ch(VECS[v].ch, VECS[v].cnt);
      a0 = acc_cnt; r0 = rd_cyc; e0 = eop_cyc;
      pulse(VECS[v].ch, int'(VECS[v].plen));
      repeat (300) @(negedge clk);
      chk({VTAG[v], " accesses"}, acc_cnt - a0, int'(VECS[v].e_acc));
      chk({VTAG[v], " read cycles"}, rd_cyc - r0, int'(VECS[v].e_rd));
      chk({VTAG[v], " deop cycles"}, eop_cyc - e0, int'(VECS[v].e_eop));
    end

    // R4: simultaneous requests on channels 0 and 2
    mode = 2'd0; blk = 4'd1; wt = 3'd1;
    arm_ch(3'b101, 8'd1);
    a0 = acc_cnt; l0 = n_log;
    pulse(3'b101, 3);
    repeat (60) @(negedge clk);
    chk("R4 first served", int'(log_q[l0]), 1);
    chk("R4 second served", int'(log_q[l0+1]), 4);
    chk("R4 accesses", acc_cnt - a0, 2);

    // R9: continuous, request held -> all 5 units, then R11 disable
    mode = 2'd3; blk = 4'd2; wt = 3'd1; dext = 1'b0;
    arm_ch(3'b010, 8'd5);
    a0 = acc_cnt; e0 = eop_cyc;
    @(negedge clk); dreq = 3'b010;
    repeat (200) @(negedge clk);
    dreq = '0;
    repeat (10) @(negedge clk);
    chk("R9 held accesses", acc_cnt - a0, 10);
    chk("R11 held deop", eop_cyc - e0, 1);
    pulse(3'b010, 4);
    repeat (30) @(negedge clk);
    chk("R11 disabled accesses", acc_cnt - a0, 10);
    chk("R11 disabled pend", int'(pend), 0);

    // R9/R10: early removal stops after one full unit
    blk = 4'd4; wt = 3'd2;
    arm_ch(3'b001, 8'd5);
    a0 = acc_cnt; r0 = rd_cyc;
    pulse(3'b001, 3);
    repeat (200) @(negedge clk);
    chk("R10 early drop accesses", acc_cnt - a0, 4);
    chk("R10 early drop read cycles", rd_cyc - r0, 8);

    // R9: late removal (after sample point) gives one more unit, 4-cycle margin
    dext = 1'b1;
    arm_ch(3'b001, 8'd5);
    a0 = acc_cnt; e0 = eop_cyc;
    @(negedge clk); dreq = 3'b001;
    while (acc_cnt - a0 < 4) @(negedge clk);
    dreq = '0;
    repeat (200) @(negedge clk);
    chk("R9 late drop accesses", acc_cnt - a0, 8);
    chk("R9 late drop deop", eop_cyc - e0, 0);
    chk("R3 pend idle", int'(pend), 0);

    chk("R5 strobe/dack consistency", bad, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule